// File: doc/BRIEF.md
# Auxiliary Timer Pair with Capture, Reload and Cascade

This block holds two 16-bit auxiliary timers that sit beside a core timer. The core timer itself, with its prescaler and gating, lives outside. Its count value and its overflow toggle latch level come in as inputs. Each auxiliary timer has a two-bit mode. In one mode it counts up or down on a tick strobe. In another it counts on every transition of the core toggle latch, so that it extends the core timer into a longer cascaded counter. In the third it snapshots the core count when its own input pin rises. In the fourth it holds a value that is pushed into the core timer when a selected trigger fires.

Each timer raises its own one-cycle interrupt pulse. In the counting modes the pulse marks a wrap. In the other modes it marks a capture or a granted reload. The external pins are asynchronous and pass through a two-stage synchroniser before their rising edge is detected. The toggle latch is synchronous to the block clock.

Top module: `aux_tmr_pair`

## Requirements
- R1: After reset every auxiliary value is 0, `irq_o` is 0 and `core_ld_o` is 0.
- R2: With `ld_i[i]` high, timer i takes its slice of `ld_val_i` on the next clock, whatever its mode, and raises no interrupt.
- R3: Mode 2'b00 counts on `tick_i[i]`: up when `dir_i[i]`=0, down when 1. Going up from 16'hFFFF gives 0, going down from 0 gives 16'hFFFF, and either wrap pulses `irq_o[i]` in the same cycle as the new value. Without a tick the value holds.
- R4: Mode 2'b01 steps the timer once per core toggle latch transition, rising or falling, in the direction given by `dir_i[i]`. The value is updated on the clock after the transition is seen. `tick_i` is ignored in this mode.
- R5: Mode 2'b10 (capture) loads `core_cnt_i` into timer i on the third clock edge after `pin_i[i]` rises, and pulses `irq_o[i]` with it. The value loaded is the one present at that edge.
- R6: In capture mode, and in reload mode (2'b11), the timer value does not count: ticks and toggle transitions leave it unchanged.
- R7: In reload mode, `rld_sel_i[2i+1:2i]` chooses the trigger. 00 selects a pin rising edge, which gives `core_ld_o` on the third edge. 01 selects a rising toggle latch edge, 10 a falling one and 11 either. A toggle trigger gives `core_ld_o` one clock after the transition, as a one-cycle pulse with the timer value on `core_ld_val_o`.
- R8: A granted reload pulses `irq_o[i]` of the granted timer together with `core_ld_o`.
- R9: When both timers request a reload in the same cycle, timer 0 is granted, and only `irq_o[0]` pulses.
- R10: A toggle transition that the trigger selection does not include produces no `core_ld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_cnt_i | input | 16 | Current core timer count |
| core_tgl_i | input | 1 | Core overflow toggle latch level |
| mode_i | input | 4 | Two-bit mode per timer (timer 0 in bits 1:0) |
| dir_i | input | 2 | Count direction per timer, 1 = down |
| tick_i | input | 2 | Count strobe per timer for mode 00 |
| pin_i | input | 2 | Asynchronous capture/reload pin per timer |
| rld_sel_i | input | 4 | Two-bit reload trigger select per timer |
| ld_i | input | 2 | Direct value load per timer |
| ld_val_i | input | 32 | Load values, timer 0 in bits 15:0 |
| aux_val_o | output | 32 | Timer values, timer 0 in bits 15:0 |
| core_ld_o | output | 1 | One-cycle load strobe for the core timer |
| core_ld_val_o | output | 16 | Value for the core timer to load |
| irq_o | output | 2 | One-cycle interrupt pulse per timer |

## Verification
Results that come from a load, a tick or a toggle transition appear one cycle after the input is driven. Results that come from a pin edge appear three cycles after it: two synchroniser stages, then the registered result. The stimulus task queues each expected value tagged with the cycle it is due. A monitor then compares it on the falling edge of exactly that cycle. The neighbouring cycles are also queued where a pulse must be only one cycle wide, or where a result must not yet have appeared.

// File: rtl/aux_tmr_pkg.sv
package aux_tmr_pkg;

    typedef enum logic [1:0] {
        MODE_COUNT   = 2'b00,
        MODE_CASCADE = 2'b01,
        MODE_CAPTURE = 2'b10,
        MODE_RELOAD  = 2'b11
    } aux_mode_e;

    typedef enum logic [1:0] {
        TRIG_PIN      = 2'b00,
        TRIG_TGL_RISE = 2'b01,
        TRIG_TGL_FALL = 2'b10,
        TRIG_TGL_ANY  = 2'b11
    } rld_trig_e;

endpackage

// File: rtl/aux_edge_sync.sv
module aux_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    // Edge is seen once the synchronised level has passed all stages
    assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/aux_unit.sv
module aux_unit
    import aux_tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  aux_mode_e    mode_i,
    input  rld_trig_e    trig_i,
    input  logic         dir_i,
    input  logic         tick_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         pin_rise_i,
    input  logic         tgl_rise_i,
    input  logic         tgl_fall_i,
    input  logic [W-1:0] core_cnt_i,
    output logic [W-1:0] val_o,
    output logic         irq_o,
    output logic         rld_req_o
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         irq;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     step;
    logic     trig_hit;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        step     = 1'b0;
        unique case (mode_i)
            MODE_COUNT:   step = tick_i;
            MODE_CASCADE: step = tgl_rise_i | tgl_fall_i;
            MODE_CAPTURE: begin
                if (pin_rise_i) begin
                    st_d.val = core_cnt_i;
                    st_d.irq = 1'b1;
                end
            end
            default: ;
        endcase
        if (step) begin
            if (dir_i) begin
                st_d.val = st_q.val - 1'b1;
                st_d.irq = (st_q.val == '0);
            end else begin
                st_d.val = st_q.val + 1'b1;
                st_d.irq = &st_q.val;
            end
        end
        if (ld_i) begin
            st_d.val = ld_val_i;
            st_d.irq = 1'b0;
        end
    end

    always_comb begin
        unique case (trig_i)
            TRIG_PIN:      trig_hit = pin_rise_i;
            TRIG_TGL_RISE: trig_hit = tgl_rise_i;
            TRIG_TGL_FALL: trig_hit = tgl_fall_i;
            default:       trig_hit = tgl_rise_i | tgl_fall_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign val_o     = st_q.val;
    assign irq_o     = st_q.irq;
    assign rld_req_o = (mode_i == MODE_RELOAD) && trig_hit;
endmodule

// File: rtl/aux_rld_arb.sv
module aux_rld_arb #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [N-1:0]   req_i,
    input  logic [N*W-1:0] vals_i,
    output logic           ld_o,
    output logic [W-1:0]   val_o,
    output logic [N-1:0]   gnt_o
);
    typedef struct packed {
        logic         ld;
        logic [W-1:0] val;
        logic [N-1:0] gnt;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ld  = 1'b0;
        st_d.gnt = '0;
        // Scan from the top so the lowest requesting index is applied last
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                st_d.ld     = 1'b1;
                st_d.gnt    = '0;
                st_d.gnt[i] = 1'b1;
                st_d.val    = vals_i[i*W +: W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ld_o  = st_q.ld;
    assign val_o = st_q.val;
    assign gnt_o = st_q.gnt;
endmodule

// File: rtl/aux_tmr_pair.sv
module aux_tmr_pair
    import aux_tmr_pkg::*;
#(
    parameter int W       = 16,
    parameter int N       = 2,
    parameter int SYNC_ST = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [W-1:0]   core_cnt_i,
    input  logic           core_tgl_i,
    input  logic [2*N-1:0] mode_i,
    input  logic [N-1:0]   dir_i,
    input  logic [N-1:0]   tick_i,
    input  logic [N-1:0]   pin_i,
    input  logic [2*N-1:0] rld_sel_i,
    input  logic [N-1:0]   ld_i,
    input  logic [N*W-1:0] ld_val_i,
    output logic [N*W-1:0] aux_val_o,
    output logic           core_ld_o,
    output logic [W-1:0]   core_ld_val_o,
    output logic [N-1:0]   irq_o
);
    typedef struct packed {
        logic tgl;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    tgl_rise, tgl_fall;

    logic [N-1:0] pin_rise;
    logic [N-1:0] rld_req;
    logic [N-1:0] unit_irq;
    logic [N-1:0] gnt;

    always_comb begin
        st_d     = st_q;
        st_d.tgl = core_tgl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tgl_rise =  core_tgl_i & ~st_q.tgl;
    assign tgl_fall = ~core_tgl_i &  st_q.tgl;

    for (genvar g = 0; g < N; g++) begin : g_unit
        aux_edge_sync #(.STAGES(SYNC_ST)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (pin_i[g]),
            .rise_o (pin_rise[g])
        );

        aux_unit #(.W(W)) u_tmr (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .mode_i     (aux_mode_e'(mode_i[2*g +: 2])),
            .trig_i     (rld_trig_e'(rld_sel_i[2*g +: 2])),
            .dir_i      (dir_i[g]),
            .tick_i     (tick_i[g]),
            .ld_i       (ld_i[g]),
            .ld_val_i   (ld_val_i[g*W +: W]),
            .pin_rise_i (pin_rise[g]),
            .tgl_rise_i (tgl_rise),
            .tgl_fall_i (tgl_fall),
            .core_cnt_i (core_cnt_i),
            .val_o      (aux_val_o[g*W +: W]),
            .irq_o      (unit_irq[g]),
            .rld_req_o  (rld_req[g])
        );
    end

    aux_rld_arb #(.W(W), .N(N)) u_arb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (rld_req),
        .vals_i (aux_val_o),
        .ld_o   (core_ld_o),
        .val_o  (core_ld_val_o),
        .gnt_o  (gnt)
    );

    assign irq_o = unit_irq | gnt;
endmodule

// File: rtl/aux_tmr_pair_chk.sv
module aux_tmr_pair_chk #(
    parameter int W = 16,
    parameter int N = 2
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [2*N-1:0] mode_i,
    input logic [N-1:0]   ld_i,
    input logic [N*W-1:0] ld_val_i,
    input logic [N-1:0]   pin_rise_i,
    input logic [N-1:0]   rld_req_i,
    input logic [W-1:0]   core_cnt_i,
    input logic [N*W-1:0] aux_val_o,
    input logic           core_ld_o,
    input logic [W-1:0]   core_ld_val_o,
    input logic [N-1:0]   irq_o
);
    for (genvar g = 0; g < N; g++) begin : g_chk
        p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ld_i[g] |=> aux_val_o[g*W +: W] == $past(ld_val_i[g*W +: W]));

        p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[2*g +: 2] == 2'b10 && pin_rise_i[g] && !ld_i[g])
            |=> (aux_val_o[g*W +: W] == $past(core_cnt_i)) && irq_o[g]);

        p_reload_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[2*g +: 2] == 2'b11 && !ld_i[g]) |=> $stable(aux_val_o[g*W +: W]));
    end

    p_lowest_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rld_req_i[0] |=> core_ld_o && (core_ld_val_o == $past(aux_val_o[W-1:0])));

    p_no_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|rld_req_i) |=> !core_ld_o);

    p_reload_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_ld_o |-> (|irq_o));
endmodule

bind aux_tmr_pair aux_tmr_pair_chk #(.W(W), .N(N)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .ld_i          (ld_i),
    .ld_val_i      (ld_val_i),
    .pin_rise_i    (pin_rise),
    .rld_req_i     (rld_req),
    .core_cnt_i    (core_cnt_i),
    .aux_val_o     (aux_val_o),
    .core_ld_o     (core_ld_o),
    .core_ld_val_o (core_ld_val_o),
    .irq_o         (irq_o)
);

// File: tb/aux_tmr_pair_tb.sv
module aux_tmr_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] core_cnt = '0;
    logic        core_tgl = 1'b0;
    logic [3:0]  mode = 4'b1010;
    logic [1:0]  dir = '0;
    logic [1:0]  tick = '0;
    logic [1:0]  pin = '0;
    logic [3:0]  rsel = '0;
    logic [1:0]  ld = '0;
    logic [31:0] ld_val = '0;
    logic [31:0] aux_val;
    logic        core_ld;
    logic [15:0] core_ld_val;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] v;
        string       req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aux_tmr_pair u_dut (
        .clk_i(clk), .rst_ni(rst_n), .core_cnt_i(core_cnt), .core_tgl_i(core_tgl),
        .mode_i(mode), .dir_i(dir), .tick_i(tick), .pin_i(pin), .rld_sel_i(rsel),
        .ld_i(ld), .ld_val_i(ld_val), .aux_val_o(aux_val), .core_ld_o(core_ld),
        .core_ld_val_o(core_ld_val), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // sel: 0 timer0 value, 1 timer1 value, 2 core load value, 3 irq, 4 core load strobe
    function automatic logic [31:0] observe(int sel);
        case (sel)
            0:       return {16'h0, aux_val[15:0]};
            1:       return {16'h0, aux_val[31:16]};
            2:       return {16'h0, core_ld_val};
            3:       return {30'h0, irq};
            default: return {31'h0, core_ld};
        endcase
    endfunction

    task automatic expect_at(int lat, int sel, logic [31:0] v, string req);
        item_t it;
        it.due = cyc + lat;
        it.sel = sel;
        it.v   = v;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each queued item on the falling edge of its due cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                chk(sb[i].req, observe(sb[i].sel), sb[i].v);
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", aux_val, 32'h0);
        chk("R1", {30'h0, irq}, 32'h0);
        chk("R1", {31'h0, core_ld}, 32'h0);
        wait_n(1);

        // R2 and R3: timer 0 counts up through the wrap
        mode[1:0] = 2'b00; ld = 2'b01; ld_val[15:0] = 16'hFFFE;
        expect_at(1, 0, 32'hFFFE, "R2");
        wait_n(1);
        ld = 2'b00; tick[0] = 1'b1; dir[0] = 1'b0;
        expect_at(1, 0, 32'hFFFF, "R3");
        expect_at(1, 3, 32'h0, "R3");
        expect_at(2, 0, 32'h0, "R3");
        expect_at(2, 3, 32'h1, "R3");
        wait_n(2);
        tick[0] = 1'b0;
        expect_at(1, 0, 32'h0, "R3");
        expect_at(1, 3, 32'h0, "R3");
        wait_n(1);

        // R3: timer 1 counts down through zero
        mode[3:2] = 2'b00; ld = 2'b10; ld_val[31:16] = 16'h0001; dir[1] = 1'b1;
        expect_at(1, 1, 32'h1, "R2");
        wait_n(1);
        ld = 2'b00; tick[1] = 1'b1;
        expect_at(1, 1, 32'h0, "R3");
        expect_at(1, 3, 32'h0, "R3");
        expect_at(2, 1, 32'hFFFF, "R3");
        expect_at(2, 3, 32'h2, "R3");
        wait_n(2);
        tick[1] = 1'b0; mode[3:2] = 2'b10;
        wait_n(1);

        // R4: timer 0 cascaded on toggle transitions
        mode[1:0] = 2'b01; ld = 2'b01; ld_val[15:0] = 16'h0007; dir[0] = 1'b0;
        expect_at(1, 0, 32'h7, "R2");
        wait_n(1);
        ld = 2'b00; tick[0] = 1'b1;
        expect_at(1, 0, 32'h7, "R4");
        wait_n(1);
        core_tgl = 1'b1;
        expect_at(1, 0, 32'h8, "R4");
        wait_n(1);
        expect_at(1, 0, 32'h8, "R4");
        wait_n(1);
        core_tgl = 1'b0;
        expect_at(1, 0, 32'h9, "R4");
        wait_n(1);
        tick[0] = 1'b0; mode[1:0] = 2'b10;
        wait_n(1);

        // R5 and R6: timer 1 captures the core count on its pin
        tick[1] = 1'b1; core_cnt = 16'hABCD; pin[1] = 1'b1;
        expect_at(1, 1, 32'hFFFF, "R6");
        expect_at(2, 1, 32'hFFFF, "R5");
        expect_at(3, 1, 32'hABCD, "R5");
        expect_at(3, 3, 32'h2, "R5");
        wait_n(3);
        expect_at(1, 3, 32'h0, "R5");
        wait_n(2);
        pin[1] = 1'b0; tick[1] = 1'b0;
        wait_n(3);

        // R7 and R8: pin-triggered reload from timer 0
        mode[1:0] = 2'b11; rsel[1:0] = 2'b00; ld = 2'b01; ld_val[15:0] = 16'h5555;
        expect_at(1, 0, 32'h5555, "R2");
        wait_n(1);
        ld = 2'b00; pin[0] = 1'b1; tick[0] = 1'b1;
        expect_at(1, 4, 32'h0, "R7");
        expect_at(2, 4, 32'h0, "R7");
        expect_at(3, 4, 32'h1, "R7");
        expect_at(3, 2, 32'h5555, "R7");
        expect_at(3, 3, 32'h1, "R8");
        expect_at(4, 4, 32'h0, "R7");
        expect_at(4, 0, 32'h5555, "R6");
        wait_n(4);
        pin[0] = 1'b0; tick[0] = 1'b0;
        wait_n(3);

        // R7 and R10: toggle-edge trigger selections
        rsel[1:0] = 2'b01; core_tgl = 1'b1;
        expect_at(1, 4, 32'h1, "R7");
        expect_at(1, 2, 32'h5555, "R7");
        expect_at(2, 4, 32'h0, "R7");
        wait_n(2);
        core_tgl = 1'b0;
        expect_at(1, 4, 32'h0, "R10");
        wait_n(2);
        rsel[1:0] = 2'b10; core_tgl = 1'b1;
        expect_at(1, 4, 32'h0, "R10");
        wait_n(1);
        core_tgl = 1'b0;
        expect_at(1, 4, 32'h1, "R7");
        wait_n(2);
        rsel[1:0] = 2'b11; core_tgl = 1'b1;
        expect_at(1, 4, 32'h1, "R7");
        wait_n(1);
        core_tgl = 1'b0;
        expect_at(1, 4, 32'h1, "R7");
        wait_n(2);

        // R9: both timers request together, timer 0 wins
        rsel = 4'b0101; mode[3:2] = 2'b11; ld = 2'b10; ld_val[31:16] = 16'hAAAA;
        expect_at(1, 1, 32'hAAAA, "R2");
        wait_n(1);
        ld = 2'b00; core_tgl = 1'b1;
        expect_at(1, 4, 32'h1, "R9");
        expect_at(1, 2, 32'h5555, "R9");
        expect_at(1, 3, 32'h1, "R9");
        wait_n(2);
        core_tgl = 1'b0;
        expect_at(1, 4, 32'h0, "R10");
        wait_n(2);
        rsel[1:0] = 2'b10; core_tgl = 1'b1;
        expect_at(1, 2, 32'hAAAA, "R8");
        expect_at(1, 3, 32'h2, "R8");
        wait_n(4);

        if (sb.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard %0d items left, expected 0", sb.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule